// File: doc/BRIEF.md
# SQE Heartbeat Pulse Generator

This block belongs to the transmit side of a 10BASE-T physical-layer device. After each frame it tells the MAC that the collision-detect path still works. It does this by pulling the active-low collision indicator low for a short, fixed time, a little after the frame has left the line. The pulse is timed from the last rising transition of the Manchester-encoded transmit line, not from the release of transmit enable. When the device uses an attachment-unit cable, an external transceiver makes this pulse instead, so the block stays silent.

The block runs on a bit-rate clock, 10 MHz, where one cycle is one bit time. A rising transition is a cycle in which `tx_line` is sampled 1 after it was sampled 0 on the previous edge, while `tx_en_n` is sampled 0. Parameter `DELAY_BITS` sets the delay from the last rise to the start of the pulse. Its default is 10 and it must lie in 6..16, which is 0.6 to 1.6 us. Parameter `WIDTH_BITS` sets the pulse width. Its default is 10 and it must lie in 5..15. Both ranges are checked at elaboration. The `coll_n` output is meant to be ANDed outside the block with the jabber logic's own collision indicator.

The control is a four-state machine. IDLE goes to FRAME when `tx_en_n` is low. FRAME goes to WAIT when `tx_en_n` goes high, provided the frame held at least one rise and `aui_sel` is low; otherwise FRAME goes back to IDLE. WAIT goes to FRAME when `tx_en_n` goes low again (cancel). WAIT goes to IDLE when `aui_sel` is high (suppress). WAIT goes to PULSE once the delay since the last rise has run out. PULSE always lasts its full width. At its end it goes to FRAME if `tx_en_n` is low, and to IDLE otherwise. `coll_n` is low exactly while the state is PULSE.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: After reset `coll_n` is 1 and stays 1 until a frame has been sent.
- R2: In twisted-pair mode (`aui_sel` = 0), a frame that holds at least one rise produces exactly one low pulse on `coll_n`. The pulse starts only after `tx_en_n` has been sampled high.
- R3: Each pulse keeps `coll_n` low for exactly `WIDTH_BITS` consecutive cycles (10 by default).
- R4: Let r be the clock edge of the frame's last rise and e the first edge at which `tx_en_n` is sampled high. `coll_n` goes low after edge max(r + `DELAY_BITS`, e + 1).
- R5: If `aui_sel` is 1 at the frame's end, no pulse is produced. If `aui_sel` is sampled 1 while the pulse is still pending, the pulse is dropped.
- R6: If `tx_en_n` is sampled low again before the pending pulse has started, that pulse is cancelled. The new frame then earns its own single pulse.
- R7: A pulse that has started runs its full width whatever `tx_en_n`, `tx_line` or `aui_sel` do. It is never stretched or repeated. A frame that starts during a pulse and is still in progress when the pulse ends earns its own pulse. A frame that both starts and ends during a pulse earns none.
- R8: A frame with no rise, including one whose line is held high from before `tx_en_n` fell, produces no pulse.
- R9: Transitions on `tx_line` while `tx_en_n` is high start no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one cycle per bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_n | input | 1 | Active-low transmit enable from the MAC |
| tx_line | input | 1 | Manchester-encoded transmit line |
| aui_sel | input | 1 | 1 selects attachment-unit cable mode, 0 selects twisted pair |
| coll_n | output | 1 | Active-low collision indicator carrying the heartbeat |

## Verification
`coll_n` comes straight from the state register, so a stimulus sampled at edge n shows up on `coll_n` just after edge n. The bench drives inputs on the falling clock edge. A behavioural model then works out, at the rising edge, the level expected after that edge, and the bench compares it with `coll_n` at the next falling edge, every cycle. Separate measured checks confirm the timing. The first low sample comes `DELAY_BITS` + 1 falling edges after the step that drove the last rise, or 2 after the step that raised `tx_en_n` when the frame ends late. The low run counts exactly `WIDTH_BITS` samples.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_FRAME = 2'd1,
        HB_WAIT  = 2'd2,
        HB_PULSE = 2'd3
    } hb_state_t;

endpackage

// File: rtl/sqe_line_tracker.sv
module sqe_line_tracker #(
    parameter int unsigned DELAY_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_n,
    input  logic tx_line,
    output logic rise_seen,
    output logic delay_met
);

    localparam int unsigned SW  = $clog2(DELAY_BITS + 1);
    localparam logic [SW-1:0] SAT = SW'(DELAY_BITS - 1);

    logic          line_q;
    logic          en_q;
    logic          seen_q;
    logic [SW-1:0] since_q;
    logic          rise;
    logic          frame_start;

    assign rise        = tx_line & ~line_q & ~tx_en_n;
    assign frame_start = ~tx_en_n & en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            en_q    <= 1'b1;
            seen_q  <= 1'b0;
            since_q <= SAT;
        end else begin
            line_q <= tx_line;
            en_q   <= tx_en_n;
            if (frame_start) begin
                seen_q <= rise;
            end else if (rise) begin
                seen_q <= 1'b1;
            end
            if (rise) begin
                since_q <= '0;
            end else if (since_q != SAT) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    assign rise_seen = seen_q;
    assign delay_met = (since_q == SAT);

endmodule

// File: rtl/sqe_pulse_timer.sv
module sqe_pulse_timer #(
    parameter int unsigned WIDTH_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = $clog2(WIDTH_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH_BITS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/sqe_heartbeat_gen.sv
module sqe_heartbeat_gen
    import sqe_pkg::*;
#(
    parameter int unsigned DELAY_BITS = 10,
    parameter int unsigned WIDTH_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_n,
    input  logic tx_line,
    input  logic aui_sel,
    output logic coll_n
);

    if (DELAY_BITS < 6 || DELAY_BITS > 16) begin : g_bad_delay
        $error("DELAY_BITS must lie in 6..16");
    end
    if (WIDTH_BITS < 5 || WIDTH_BITS > 15) begin : g_bad_width
        $error("WIDTH_BITS must lie in 5..15");
    end

    hb_state_t state_q;
    hb_state_t state_d;
    logic      rise_seen;
    logic      delay_met;
    logic      width_done;
    logic      start_pulse;
    logic      pulsing;

    sqe_line_tracker #(.DELAY_BITS(DELAY_BITS)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en_n   (tx_en_n),
        .tx_line   (tx_line),
        .rise_seen (rise_seen),
        .delay_met (delay_met)
    );

    assign pulsing     = (state_q == HB_PULSE);
    assign start_pulse = (state_q == HB_WAIT) && (state_d == HB_PULSE);

    sqe_pulse_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_pulse),
        .run     (pulsing),
        .done    (width_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HB_IDLE: begin
                if (!tx_en_n) state_d = HB_FRAME;
            end
            HB_FRAME: begin
                if (tx_en_n) begin
                    state_d = (aui_sel || !rise_seen) ? HB_IDLE : HB_WAIT;
                end
            end
            HB_WAIT: begin
                if (!tx_en_n)      state_d = HB_FRAME;
                else if (aui_sel)  state_d = HB_IDLE;
                else if (delay_met) state_d = HB_PULSE;
            end
            HB_PULSE: begin
                if (width_done) state_d = tx_en_n ? HB_IDLE : HB_FRAME;
            end
            default: state_d = HB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        coll_n = !pulsing;
    end

endmodule

// File: rtl/sqe_heartbeat_chk.sv
module sqe_heartbeat_chk #(
    parameter int unsigned DELAY_BITS = 10,
    parameter int unsigned WIDTH_BITS = 10
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en_n,
    input logic tx_line,
    input logic aui_sel,
    input logic coll_n
);

    localparam int unsigned LW = $clog2(WIDTH_BITS + 2);
    localparam int unsigned GW = $clog2(DELAY_BITS + 1);

    logic [LW-1:0] low_run;
    logic [GW-1:0] gap;
    logic          line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
            gap     <= '0;
            line_q  <= 1'b0;
        end else begin
            line_q <= tx_line;
            if (coll_n)                              low_run <= '0;
            else if (low_run != LW'(WIDTH_BITS + 1)) low_run <= low_run + 1'b1;
            if (tx_line && !line_q && !tx_en_n)      gap <= '0;
            else if (gap != GW'(DELAY_BITS))         gap <= gap + 1'b1;
        end
    end

    // R2: a pulse begins only once transmit enable has been released
    a_r2_after_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coll_n) |-> $past(tx_en_n));

    // R3: the low run is exactly the programmed width
    a_r3_width_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_n) |-> (low_run == LW'(WIDTH_BITS)));

    // R4: never earlier than the delay after the last rise
    a_r4_delay_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coll_n) |-> (gap >= GW'(DELAY_BITS)));

    // R5: no pulse starts in cable mode
    a_r5_aui_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coll_n) |-> !$past(aui_sel));

    // R7: a pulse is never stretched
    a_r7_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LW'(WIDTH_BITS));

endmodule

bind sqe_heartbeat_gen sqe_heartbeat_chk #(
    .DELAY_BITS (DELAY_BITS),
    .WIDTH_BITS (WIDTH_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en_n (tx_en_n),
    .tx_line (tx_line),
    .aui_sel (aui_sel),
    .coll_n  (coll_n)
);

// File: tb/test_sqe_heartbeat_gen.sv
module test_sqe_heartbeat_gen;

    localparam int PERIOD = 100;
    localparam int DLY    = 10;
    localparam int WID    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en_n = 1'b1;
    logic tx_line = 1'b0;
    logic aui_sel = 1'b0;
    logic coll_n;

    int vectors = 0;
    int miscmp  = 0;
    string tag = "R1";

    sqe_heartbeat_gen #(.DELAY_BITS(DLY), .WIDTH_BITS(WID)) i_sqe_heartbeat_gen (
        .clk(clk), .rst_n(rst_n), .tx_en_n(tx_en_n), .tx_line(tx_line),
        .aui_sel(aui_sel), .coll_n(coll_n)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference: mode 0 idle, 1 sending, 2 pending, 3 pulsing
    int mode = 0, cyc = 0, last_rise = 0, ps = 0;
    bit prev_line = 0, prev_en = 1, got = 0;
    logic exp_coll = 1'b1;

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 0; cyc = 0; last_rise = 0; ps = 0;
            prev_line = 0; prev_en = 1; got = 0;
        end else begin
            int nxt;
            cyc++;
            nxt = mode;
            if (mode == 0) begin
                if (!tx_en_n) nxt = 1;
            end else if (mode == 1) begin
                if (tx_en_n) nxt = (aui_sel || !got) ? 0 : 2;
            end else if (mode == 2) begin
                if (!tx_en_n) nxt = 1;
                else if (aui_sel) nxt = 0;
                else if (cyc >= last_rise + DLY) begin nxt = 3; ps = cyc; end
            end else begin
                if (cyc == ps + WID) nxt = tx_en_n ? 0 : 1;
            end
            mode = nxt;
            if (!tx_en_n) begin
                if (prev_en) got = 0;
                if (tx_line && !prev_line) begin got = 1; last_rise = cyc; end
            end
            prev_line = tx_line;
            prev_en = tx_en_n;
        end
        exp_coll = (mode != 3);
    end

    // measurement bookkeeping in step units
    int step_no = 0, rise_step = 0, end_step = 0, fell_step = 0;
    int low_samples = 0, falls = 0;
    logic seen_prev = 1'b1;

    task automatic check_int(input string t, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s: measured %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic step(input logic en, input logic ln, input logic au);
        @(negedge clk);
        step_no++;
        vectors++;
        if (coll_n !== exp_coll) begin
            miscmp++;
            $display("FAIL %s: coll_n=%b expected %b at step %0d", tag, coll_n, exp_coll, step_no);
        end
        if (coll_n === 1'b0) begin
            low_samples++;
            if (seen_prev) begin falls++; fell_step = step_no; end
        end
        seen_prev = coll_n;
        if (!en && ln && !tx_line) rise_step = step_no;
        if (en && !tx_en_n) end_step = step_no;
        tx_en_n = en; tx_line = ln; aui_sel = au;
    endtask

    task automatic phase(input string t);
        tag = t; low_samples = 0; falls = 0;
    endtask

    task automatic frame(input int n, input logic au);
        for (int i = 0; i < n; i++) step(1'b0, 1'(i % 2), au);
    endtask

    task automatic idle(input int n, input logic au);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, au);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        phase("R1");
        idle(8, 1'b0);
        check_int("R1 pulses after reset", falls, 0);

        // R2, R3: plain frame
        phase("R2");
        frame(20, 1'b0);
        idle(30, 1'b0);
        check_int("R2 pulses per frame", falls, 1);
        check_int("R4 start offset from last rise", fell_step - rise_step, DLY + 1);
        check_int("R3 pulse width", low_samples, WID);

        // R4: frame ends well after its last rise
        phase("R4");
        frame(8, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0);
        idle(30, 1'b0);
        check_int("R4 start after late end", fell_step - end_step, 2);
        check_int("R3 width after late end", low_samples, WID);

        // R5: cable mode at end, and cable mode while pending
        phase("R5");
        frame(12, 1'b1);
        idle(30, 1'b1);
        frame(12, 1'b0);
        idle(3, 1'b0);
        idle(30, 1'b1);
        check_int("R5 pulses in cable mode", falls, 0);

        // R6: restart before the pulse begins
        phase("R6");
        frame(10, 1'b0);
        idle(4, 1'b0);
        frame(10, 1'b0);
        idle(30, 1'b0);
        check_int("R6 pulses after cancel", falls, 1);

        // R7: new frame overlapping a pulse, continuing past it
        phase("R7");
        frame(10, 1'b0);
        idle(12, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b0, 1'(i % 2), 1'(i % 3 == 0));
        idle(30, 1'b0);
        check_int("R7 pulses for overlapping frame", falls, 2);
        check_int("R7 total low cycles", low_samples, 2 * WID);

        // R7: frame wholly inside a pulse
        phase("R7");
        frame(10, 1'b0);
        idle(11, 1'b0);
        frame(3, 1'b0);
        idle(30, 1'b0);
        check_int("R7 frame inside pulse", falls, 1);

        // R8: frames without a rise
        phase("R8");
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0);
        idle(30, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0);
        idle(30, 1'b0);
        check_int("R8 pulses without rise", falls, 0);

        // R9: line activity with enable released
        phase("R9");
        for (int i = 0; i < 40; i++) step(1'b1, 1'(i % 2), 1'b0);
        idle(30, 1'b0);
        check_int("R9 pulses from idle toggling", falls, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        miscmp++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

endmodule